// File: doc/BRIEF.md
# Interrupt Source Coalescing Gate

This block sits between a set of interrupt sources and a routing stage. Each source owns a two-bit state: a "forwarded" bit and a "retrigger" bit. The first trigger on an idle source forwards the source number to the routing stage. Further triggers are only remembered until software ends the interrupt. As a result, a source is never handed on twice before it has been serviced. When the interrupt is ended, the remembered bit decides whether the source goes out again.

Software manages the sources through a load/store port decoded by page and offset. Every management load gives back the state as it stood before the access, and applies its own change in the same cycle. Sources can be edge-type or level-type. A level-type source also reports whether its input is still high, and it fires again when the interrupt is ended while that input stays high. Forwarded source numbers leave through a ready/valid channel. The lowest-numbered waiting source goes first.

Top module: `pqsb_top`

## Requirements
- R1: After reset every source holds the state given by the RESET_PQ parameter, no notify is offered and no load response is valid.
- R2: State encoding is {P,Q} with P in bit 1 and Q in bit 0. A trigger moves 00 to 10 and requests a notify; it moves 10 or 11 to 11 and leaves 01 at 01, in both cases without a notify. For an edge-type source a trigger is a rising edge of its src_in bit.
- R3: A load at management offset 0x000 ends the interrupt: 10 becomes 00, 11 becomes 10 with a new notify, and 00 and 01 are left unchanged.
- R4: A store at management offset 0x400 ends the interrupt exactly like R3 when STORE_EOI_EN is 1, and has no effect when it is 0.
- R5: A load at management offset 0x800 returns the state and changes nothing.
- R6: Loads at offsets 0xC00, 0xD00, 0xE00 and 0xF00 force the state to 00, 01, 10 and 11 respectively (offset bits 9:8 give the new value).
- R7: A store at management offset 0x800 acts as a trigger, as in R2.
- R8: Address bits above PAGE_SHIFT select the source. With TWO_PAGE set, bit PAGE_SHIFT-1 picks the management page when 1 and the trigger page when 0. Any store to the trigger page is a trigger, and a load from it returns 000 and changes nothing. Management stores to offsets not listed above are ignored. Without TWO_PAGE, the whole page is the management page.
- R9: A source marked in LEVEL_MASK reports its registered input level in rd_data bit 2 and triggers on the rising edge of that input. When its interrupt is ended while the input is still high, it triggers again right after the end-of-interrupt transition.
- R10: ntf_valid stays high until ntf_ready is seen. Among waiting sources, the lowest number is offered first. A source has at most one notify outstanding, however many notify requests it makes meanwhile.
- R11: Every load produces rd_valid in the next cycle, with rd_data = {level bit, P, Q} as it was before that load.
- R12: With PQ_CHECK_EN at 0, every trigger requests a notify and leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | N_SRC | Per-source trigger inputs |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | SRC_W+PAGE_SHIFT | Access address: source number above PAGE_SHIFT, page offset below |
| rd_valid | output | 1 | Load response valid |
| rd_data | output | 3 | Previous {level bit, P, Q} of the accessed source |
| ntf_valid | output | 1 | Notify offered |
| ntf_ready | input | 1 | Routing stage accepts the notify |
| ntf_src | output | SRC_W | Number of the notified source |

## Verification
A corrupted state bit shows at the ports in one of three ways. A notify may be missing or duplicated on the channel one cycle after the trigger or end-of-interrupt that should have decided it. The next management load may return the wrong old value one cycle after it is issued. An ended source may fail to come back. The scoreboard keeps a bench-side model of each source and compares every load response and every accepted notify in order. A skipped merge or a lost retrigger therefore appears at the first handshake that follows it. Holding ready low checks ordering and merging, and a second instance covers the single-page, unchecked and store-EOI-disabled variants.

// File: rtl/pqsb_pkg.sv
package pqsb_pkg;

   typedef logic [1:0] pq_t;

   localparam pq_t PQ_IDLE   = 2'b00;
   localparam pq_t PQ_OFF    = 2'b01;
   localparam pq_t PQ_PEND   = 2'b10;
   localparam pq_t PQ_QUEUED = 2'b11;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_EOI,
      OP_GET,
      OP_SET,
      OP_TRIG
   } op_e;

   typedef struct packed {
      pq_t  pq;
      logic fwd;
   } pq_step_t;

   // trigger step; with checking off the event always goes through untouched
   function automatic pq_step_t pq_trigger(pq_t s, logic checked);
      pq_step_t r;
      r.pq  = s;
      r.fwd = 1'b0;
      if (!checked) begin
         r.fwd = 1'b1;
      end else begin
         case (s)
            PQ_IDLE:            begin r.pq = PQ_PEND; r.fwd = 1'b1; end
            PQ_PEND, PQ_QUEUED: r.pq = PQ_QUEUED;
            default:            r.pq = s;
         endcase
      end
      return r;
   endfunction

   function automatic pq_step_t pq_eoi(pq_t s);
      pq_step_t r;
      r.pq  = s;
      r.fwd = 1'b0;
      case (s)
         PQ_PEND:   r.pq = PQ_IDLE;
         PQ_QUEUED: begin r.pq = PQ_PEND; r.fwd = 1'b1; end
         default:   r.pq = s;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pqsb_decode.sv
module pqsb_decode
   import pqsb_pkg::*;
#(
   parameter int N_SRC        = 8,
   parameter int PAGE_SHIFT   = 13,
   parameter bit TWO_PAGE     = 1'b1,
   parameter bit STORE_EOI_EN = 1'b1,
   localparam int SRC_W       = (N_SRC > 1) ? $clog2(N_SRC) : 1,
   localparam int ADDR_W      = SRC_W + PAGE_SHIFT
) (
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   output op_e               op,
   output pq_t               set_val,
   output logic [SRC_W-1:0]  src,
   output logic              rd_hit
);

   localparam int MIN_SHIFT = 12 + (TWO_PAGE ? 1 : 0);

   if (PAGE_SHIFT < MIN_SHIFT) begin : g_bad_shift
      $error("pqsb_decode: PAGE_SHIFT too small for the offset map");
   end
   if (N_SRC < 1) begin : g_bad_count
      $error("pqsb_decode: N_SRC must be at least 1");
   end

   logic       mgmt;
   logic       in_range;
   logic [3:0] sel;
   logic       unused_addr;

   assign src         = acc_addr[ADDR_W-1:PAGE_SHIFT];
   assign sel         = acc_addr[11:8];
   assign set_val     = sel[1:0];
   assign unused_addr = ^acc_addr;

   if (TWO_PAGE) begin : g_two_page
      assign mgmt = acc_addr[PAGE_SHIFT-1];
   end else begin : g_one_page
      assign mgmt = 1'b1;
   end

   if (N_SRC == (1 << SRC_W)) begin : g_full_range
      assign in_range = 1'b1;
   end else begin : g_part_range
      assign in_range = ({1'b0, src} < (SRC_W+1)'(N_SRC));
   end

   assign rd_hit = in_range & mgmt;

   always_comb begin
      op = OP_NONE;
      if (acc_valid && in_range) begin
         if (!mgmt) begin
            op = acc_write ? OP_TRIG : OP_NONE;
         end else begin
            case (sel[3:2])
               2'b00: op = acc_write ? OP_NONE : OP_EOI;
               2'b01: op = (acc_write && STORE_EOI_EN) ? OP_EOI : OP_NONE;
               2'b10: op = acc_write ? OP_TRIG : OP_GET;
               default: op = acc_write ? OP_NONE : OP_SET;
            endcase
         end
      end
   end

endmodule

// File: rtl/pqsb_cell.sv
module pqsb_cell
   import pqsb_pkg::*;
#(
   parameter pq_t RESET_PQ    = PQ_IDLE,
   parameter bit  IS_LEVEL    = 1'b0,
   parameter bit  PQ_CHECK_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  op_e  op,
   input  pq_t  set_val,
   input  logic trig,
   input  logic asserted,
   output pq_t  pq,
   output logic fwd
);

   pq_t      pq_q;
   pq_t      pq_n;
   pq_step_t st_op;
   pq_step_t st_lvl;
   pq_step_t st_hw;

   // access first, then the level retrigger, then the hardware trigger
   always_comb begin
      st_op  = '{pq: pq_q, fwd: 1'b0};
      case (op)
         OP_EOI:  st_op = pq_eoi(pq_q);
         OP_SET:  st_op = '{pq: set_val, fwd: 1'b0};
         OP_TRIG: st_op = pq_trigger(pq_q, PQ_CHECK_EN);
         default: st_op = '{pq: pq_q, fwd: 1'b0};
      endcase

      st_lvl = '{pq: st_op.pq, fwd: 1'b0};
      if (IS_LEVEL && asserted && op == OP_EOI) begin
         st_lvl = pq_trigger(st_op.pq, PQ_CHECK_EN);
      end

      st_hw = '{pq: st_lvl.pq, fwd: 1'b0};
      if (trig) begin
         st_hw = pq_trigger(st_lvl.pq, PQ_CHECK_EN);
      end

      pq_n = st_hw.pq;
      fwd  = st_op.fwd | st_lvl.fwd | st_hw.fwd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pq_q <= RESET_PQ;
      else        pq_q <= pq_n;
   end

   assign pq = pq_q;

   if (PQ_CHECK_EN) begin : g_checked
      // R2: a forwarded event always leaves the source marked pending
      a_r2_fwd_marks_p : assert property (@(posedge clk) disable iff (!rst_n)
         fwd |=> pq_q[1]);
      // R2: an off source stays off without software action
      a_r2_off_absorbs : assert property (@(posedge clk) disable iff (!rst_n)
         (pq_q == PQ_OFF && (op == OP_NONE || op == OP_GET)) |=> pq_q == PQ_OFF);
   end else begin : g_unchecked
      // R12: triggers leave the state alone when checking is off
      a_r12_state_kept : assert property (@(posedge clk) disable iff (!rst_n)
         (op == OP_NONE || op == OP_GET) |=> $stable(pq_q));
   end

endmodule

// File: rtl/pqsb_notify_arb.sv
module pqsb_notify_arb #(
   parameter int N_SRC  = 8,
   localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] set_req,
   input  logic             ready,
   output logic             valid,
   output logic [SRC_W-1:0] src
);

   logic [N_SRC-1:0] waiting_q;
   logic [N_SRC-1:0] grant;
   logic [N_SRC-1:0] waiting_n;

   always_comb begin
      grant = '0;
      src   = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (waiting_q[i]) begin
            grant = '0;
            grant[i] = 1'b1;
            src = SRC_W'(i);
         end
      end
   end

   assign valid     = |waiting_q;
   assign waiting_n = (waiting_q & ~(grant & {N_SRC{ready}})) | set_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) waiting_q <= '0;
      else        waiting_q <= waiting_n;
   end

   // R10: an offered notify is held until accepted
   a_r10_hold_valid : assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> valid);
   // R10: at most one source granted
   a_r10_one_grant : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   // R10: an accepted source is retired unless it asked again
   a_r10_retire : assert property (@(posedge clk) disable iff (!rst_n)
      (valid && ready && !set_req[src]) |=> !waiting_q[$past(src)]);

endmodule

// File: rtl/pqsb_top.sv
module pqsb_top
   import pqsb_pkg::*;
#(
   parameter int             N_SRC        = 8,
   parameter int             PAGE_SHIFT   = 13,
   parameter bit             TWO_PAGE     = 1'b1,
   parameter logic [N_SRC-1:0] LEVEL_MASK = '0,
   parameter pq_t            RESET_PQ     = PQ_IDLE,
   parameter bit             STORE_EOI_EN = 1'b1,
   parameter bit             PQ_CHECK_EN  = 1'b1,
   localparam int            SRC_W        = (N_SRC > 1) ? $clog2(N_SRC) : 1,
   localparam int            ADDR_W       = SRC_W + PAGE_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_in,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              rd_valid,
   output logic [2:0]        rd_data,
   output logic              ntf_valid,
   input  logic              ntf_ready,
   output logic [SRC_W-1:0]  ntf_src
);

   logic [N_SRC-1:0] src_q;
   logic [N_SRC-1:0] rise;
   op_e              dec_op;
   pq_t              dec_set;
   logic [SRC_W-1:0] dec_src;
   logic             dec_hit;
   pq_t              pq_all   [N_SRC];
   logic [2:0]       stat_all [N_SRC];
   logic [N_SRC-1:0] fwd_all;
   logic             is_load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= '0;
      else        src_q <= src_in;
   end

   assign rise    = src_in & ~src_q;
   assign is_load = acc_valid & ~acc_write;

   pqsb_decode #(
      .N_SRC        (N_SRC),
      .PAGE_SHIFT   (PAGE_SHIFT),
      .TWO_PAGE     (TWO_PAGE),
      .STORE_EOI_EN (STORE_EOI_EN)
   ) u_decode (
      .acc_valid (acc_valid),
      .acc_write (acc_write),
      .acc_addr  (acc_addr),
      .op        (dec_op),
      .set_val   (dec_set),
      .src       (dec_src),
      .rd_hit    (dec_hit)
   );

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      op_e  cell_op;
      logic lvl;

      assign cell_op = (dec_src == SRC_W'(g)) ? dec_op : OP_NONE;
      assign lvl     = LEVEL_MASK[g] ? src_q[g] : 1'b0;

      pqsb_cell #(
         .RESET_PQ    (RESET_PQ),
         .IS_LEVEL    (LEVEL_MASK[g]),
         .PQ_CHECK_EN (PQ_CHECK_EN)
      ) u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .op       (cell_op),
         .set_val  (dec_set),
         .trig     (rise[g]),
         .asserted (lvl),
         .pq       (pq_all[g]),
         .fwd      (fwd_all[g])
      );

      assign stat_all[g] = {lvl, pq_all[g]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= is_load;
         rd_data  <= (is_load && dec_hit) ? stat_all[dec_src] : 3'b000;
      end
   end

   pqsb_notify_arb #(
      .N_SRC (N_SRC)
   ) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (fwd_all),
      .ready   (ntf_ready),
      .valid   (ntf_valid),
      .src     (ntf_src)
   );

   // R11: every load is answered in the following cycle
   a_r11_load_answered : assert property (@(posedge clk) disable iff (!rst_n)
      is_load |=> rd_valid);
   // R11: no response without a load
   a_r11_no_stray_resp : assert property (@(posedge clk) disable iff (!rst_n)
      !is_load |=> !rd_valid);
   // R10: offered source number is a real source
   a_r10_src_in_range : assert property (@(posedge clk) disable iff (!rst_n)
      ntf_valid |-> (int'(ntf_src) < N_SRC));

endmodule

// File: tb/pqsb_top_bench.sv
module pqsb_top_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  src_in = '0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [15:0] acc_addr = '0;
   logic        rd_valid;
   logic [2:0]  rd_data;
   logic        ntf_valid;
   logic        ntf_ready = 1'b1;
   logic [2:0]  ntf_src;

   logic [3:0]  a_src_in = '0;
   logic        a_acc_valid = 1'b0;
   logic        a_acc_write = 1'b0;
   logic [13:0] a_acc_addr = '0;
   logic        a_rd_valid;
   logic [2:0]  a_rd_data;
   logic        a_ntf_valid;
   logic [1:0]  a_ntf_src;

   always #5 clk = ~clk;

   pqsb_top #(
      .N_SRC (8), .PAGE_SHIFT (13), .TWO_PAGE (1'b1), .LEVEL_MASK (8'hF0),
      .RESET_PQ (2'b00), .STORE_EOI_EN (1'b1), .PQ_CHECK_EN (1'b1)
   ) u_pqsb_top (
      .clk (clk), .rst_n (rst_n), .src_in (src_in),
      .acc_valid (acc_valid), .acc_write (acc_write), .acc_addr (acc_addr),
      .rd_valid (rd_valid), .rd_data (rd_data),
      .ntf_valid (ntf_valid), .ntf_ready (ntf_ready), .ntf_src (ntf_src)
   );

   pqsb_top #(
      .N_SRC (4), .PAGE_SHIFT (12), .TWO_PAGE (1'b0), .LEVEL_MASK (4'h0),
      .RESET_PQ (2'b01), .STORE_EOI_EN (1'b0), .PQ_CHECK_EN (1'b0)
   ) u_pqsb_top_alt (
      .clk (clk), .rst_n (rst_n), .src_in (a_src_in),
      .acc_valid (a_acc_valid), .acc_write (a_acc_write), .acc_addr (a_acc_addr),
      .rd_valid (a_rd_valid), .rd_data (a_rd_data),
      .ntf_valid (a_ntf_valid), .ntf_ready (1'b1), .ntf_src (a_ntf_src)
   );

   int          checks = 0;
   int          failures = 0;
   bit          done = 1'b0;
   string       cur_req = "R1";
   logic [2:0]  exp_rd [$];
   int          exp_ntf [$];
   logic [1:0]  m_pq [8];
   logic        m_asrt [8];
   bit          defer = 1'b0;
   logic [7:0]  def_mask = '0;
   localparam logic [7:0] LVL = 8'hF0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ---------------- bench model, written from the requirements
   task automatic push_ntf(input int s);
      if (defer) def_mask[s] = 1'b1;
      else       exp_ntf.push_back(s);
   endtask

   task automatic m_trig(input int s);
      if (m_pq[s] == 2'b00) begin
         m_pq[s] = 2'b10;
         push_ntf(s);
      end else if (m_pq[s][1]) begin
         m_pq[s] = 2'b11;
      end
   endtask

   task automatic m_eoi(input int s);
      if (m_pq[s] == 2'b10) m_pq[s] = 2'b00;
      else if (m_pq[s] == 2'b11) begin
         m_pq[s] = 2'b10;
         push_ntf(s);
      end
      if (LVL[s] && m_asrt[s]) m_trig(s);
   endtask

   // ---------------- drivers (entered and left at a falling edge)
   task automatic drive_acc(input logic wr, input int s, input logic mgmt, input logic [11:0] off);
      acc_valid = 1'b1;
      acc_write = wr;
      acc_addr  = {s[2:0], mgmt, off};
      @(negedge clk);
      acc_valid = 1'b0;
      acc_write = 1'b0;
   endtask

   task automatic ld_eoi(input int s);
      exp_rd.push_back({m_asrt[s], m_pq[s]});
      m_eoi(s);
      drive_acc(1'b0, s, 1'b1, 12'h000);
   endtask

   task automatic st_eoi(input int s);
      m_eoi(s);
      drive_acc(1'b1, s, 1'b1, 12'h400);
   endtask

   task automatic get(input int s);
      exp_rd.push_back({m_asrt[s], m_pq[s]});
      drive_acc(1'b0, s, 1'b1, 12'h800);
   endtask

   task automatic setpq(input int s, input logic [1:0] v);
      exp_rd.push_back({m_asrt[s], m_pq[s]});
      m_pq[s] = v;
      drive_acc(1'b0, s, 1'b1, {2'b11, v, 8'h00});
   endtask

   task automatic inject(input int s);
      m_trig(s);
      drive_acc(1'b1, s, 1'b1, 12'h800);
   endtask

   task automatic pulse(input int s);
      m_trig(s);
      src_in[s] = 1'b1;
      @(negedge clk);
      src_in[s] = 1'b0;
      @(negedge clk);
   endtask

   task automatic level_set(input int s, input logic v);
      if (v && !m_asrt[s]) m_trig(s);
      m_asrt[s] = v;
      src_in[s] = v;
      @(negedge clk);
   endtask

   // ---------------- monitor: compare results against the expected queues
   initial begin
      forever begin
         @(negedge clk);
         #4;
         if (rst_n && rd_valid) begin
            if (exp_rd.size() == 0) chk(1'b0, {cur_req, " unexpected load response"}, int'(rd_data), -1);
            else begin
               logic [2:0] e;
               e = exp_rd.pop_front();
               chk(rd_data == e, {cur_req, " load response"}, int'(rd_data), int'(e));
            end
         end
         if (rst_n && ntf_valid && ntf_ready) begin
            if (exp_ntf.size() == 0) chk(1'b0, {cur_req, " unexpected notify"}, int'(ntf_src), -1);
            else begin
               int e;
               e = exp_ntf.pop_front();
               chk(int'(ntf_src) == e, {cur_req, " notify source"}, int'(ntf_src), e);
            end
         end
      end
   end

   // ---------------- alternate instance helpers
   task automatic a_op(input logic wr, input int s, input logic [11:0] off,
                       output logic rv, output logic [2:0] rd);
      a_acc_valid = 1'b1;
      a_acc_write = wr;
      a_acc_addr  = {s[1:0], off};
      @(negedge clk);
      a_acc_valid = 1'b0;
      a_acc_write = 1'b0;
      #4;
      rv = a_rd_valid;
      rd = a_rd_data;
      @(negedge clk);
   endtask

   task automatic a_pulse(input int s, output logic nv, output logic [1:0] ns);
      a_src_in[s] = 1'b1;
      @(negedge clk);
      a_src_in[s] = 1'b0;
      #4;
      nv = a_ntf_valid;
      ns = a_ntf_src;
      @(negedge clk);
   endtask

   // ---------------- stimulus
   initial begin
      logic       rv;
      logic [2:0] rd;
      logic       nv;
      logic [1:0] ns;
      for (int i = 0; i < 8; i++) begin
         m_pq[i] = 2'b00;
         m_asrt[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #4;
      // R1: quiet outputs right after reset
      chk(ntf_valid == 1'b0, "R1 ntf_valid after reset", int'(ntf_valid), 0);
      chk(rd_valid == 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);
      @(negedge clk);

      cur_req = "R1 R5 R11";
      for (int i = 0; i < 8; i++) get(i);

      cur_req = "R2";
      pulse(0);
      pulse(0);
      get(0);
      setpq(1, 2'b01);
      pulse(1);
      get(1);

      cur_req = "R3";
      ld_eoi(0);
      ld_eoi(0);
      ld_eoi(0);
      ld_eoi(1);

      cur_req = "R6";
      setpq(3, 2'b10);
      setpq(3, 2'b11);
      setpq(3, 2'b00);
      get(3);

      cur_req = "R7";
      inject(3);
      get(3);

      cur_req = "R4";
      inject(3);
      st_eoi(3);
      st_eoi(3);
      get(3);

      cur_req = "R8";
      m_trig(6);
      drive_acc(1'b1, 6, 1'b0, 12'h000);   // trigger-page store
      exp_rd.push_back(3'b000);
      drive_acc(1'b0, 6, 1'b0, 12'h800);   // trigger-page load
      drive_acc(1'b1, 6, 1'b1, 12'hC00);   // unlisted management store
      get(6);

      cur_req = "R9";
      level_set(4, 1'b1);
      get(4);
      ld_eoi(4);
      level_set(4, 1'b0);
      ld_eoi(4);
      get(4);

      cur_req = "R10";
      ntf_ready = 1'b0;
      defer = 1'b1;
      pulse(5);
      pulse(2);
      pulse(2);
      setpq(5, 2'b00);
      pulse(5);
      #4;
      chk(ntf_valid == 1'b1, "R10 valid held while not ready", int'(ntf_valid), 1);
      chk(ntf_src == 3'd2, "R10 lowest source offered first", int'(ntf_src), 2);
      @(negedge clk);
      defer = 1'b0;
      for (int i = 0; i < 8; i++) if (def_mask[i]) exp_ntf.push_back(i);
      def_mask = '0;
      ntf_ready = 1'b1;
      repeat (4) @(negedge clk);
      get(2);

      // alternate instance: single page, reset 01, no checking, no store EOI
      cur_req = "R12";
      a_op(1'b0, 1, 12'h800, rv, rd);
      chk(rv && rd == 3'b001, "R1 R8 reset value via single page", int'(rd), 1);
      a_pulse(0, nv, ns);
      chk(nv && ns == 2'd0, "R12 unchecked trigger notifies", int'(nv), 1);
      a_op(1'b0, 0, 12'h800, rv, rd);
      chk(rv && rd == 3'b001, "R12 unchecked trigger keeps state", int'(rd), 1);
      a_pulse(0, nv, ns);
      chk(nv && ns == 2'd0, "R12 second unchecked notify", int'(nv), 1);
      a_op(1'b0, 2, 12'hF00, rv, rd);
      chk(rv && rd == 3'b001, "R6 set returns old state", int'(rd), 1);
      a_op(1'b1, 2, 12'h400, rv, rd);
      a_op(1'b0, 2, 12'h800, rv, rd);
      chk(rv && rd == 3'b011, "R4 store EOI ignored when disabled", int'(rd), 3);

      repeat (5) @(negedge clk);
      // R10 R11: nothing left unanswered
      chk(exp_ntf.size() == 0, "R10 outstanding expected notifies", exp_ntf.size(), 0);
      chk(exp_rd.size() == 0, "R11 outstanding expected responses", exp_rd.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired in %s actual=0 expected=1", cur_req);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule